// File: doc/BRIEF.md
# Parallel NOR flash command interpreter

This block decodes the command writes that a host issues to a parallel NOR flash with a block-erase style command set. It watches a synchronous bus (address, write data, read data, write and read strobes, and a transfer-size field). Writes either carry a command byte in the low lane or, right after a program command, carry data to be merged into the array. Reads are steered by the current mode. They return array words, identification words, the query table, or the status byte.

The array sits outside the block on a storage port of byte lanes with one write enable per lane. A program operation reads the addressed word and writes back the bitwise AND of the old and new data, so bits can only go from 1 to 0. Block erase is not done here. A confirmed erase raises a one-cycle request, with the byte address, to a separate erase sequencer. Lock commands are accepted for protocol compatibility but do nothing.

The reset input is asynchronous and active low. Its release passes through a two-stage synchronizer, so the block leaves reset two rising edges after the input goes high.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset the block is in array-read mode, the status byte is 0x80 and erase_req is low. A read in array-read mode returns the storage word at word index = byte address >> log2(BUS_BYTES).
- R2: A write whose bus_size (a byte count) is not BUS_BYTES changes nothing: the mode, the status byte, the storage and erase_req all stay as they were.
- R3: In program mode the next write is always a program operation, whatever its value (0xFF included). Every byte lane of the addressed word becomes old AND new, and the mode becomes status-read.
- R4: Outside program mode, command 0xFF or 0xF0 (the low byte of the write data) returns the block to array-read mode from any mode.
- R5: From array-read or ID mode, command 0x98 enters query mode only when the word index is 0x55. At any other index it is dropped and the mode is kept.
- R6: Command 0x90 (from array-read or ID mode) enters ID mode. In ID mode the low 9 bits of the word index pick the reply: 0 gives MFG_CODE, 1 gives 0x00AD, 2 gives 0x0000, 5 gives 0x8000, and any other offset gives 0. The reply is little-endian and cut to the bus width.
- R7: Command 0x20 enters erase mode. In erase mode, 0xD0 pulses erase_req high for exactly the cycle after the write, with erase_addr holding the written byte address, and clears status bits 5 and 4. Any other value (except R4 codes) sets bits 5 and 4. Either way the mode becomes status-read.
- R8: Command 0x40 or 0x10 (from array-read or ID mode) enters program mode.
- R9: Command 0x60 enters protect mode. There, 0x01, 0xD0 and 0x2F leave the status byte unchanged, and any other value (except R4 codes) sets bits 5 and 4. Either way the mode becomes status-read.
- R10: Command 0x50 in array-read or ID mode sets the status byte to 0x80 and keeps the mode.
- R11: In status-read and erase modes a read returns the status byte in bits 7:0 with the upper bits zero. Bit 7 is ready, bit 5 is the erase error and bit 4 is the program error. With bus_re low, bus_rdata is zero.
- R12: The word index used for commands, ID offsets, query offsets and the query-entry address is the byte address shifted right by 0, 1 or 2 bits for a 1-, 2- or 4-byte bus.
- R13: In query mode, word indices 0x10 to 0x2C return table byte index-0x10, zero-extended: bytes 0 to 2 are 0x51 0x52 0x59, bytes 3 and 4 are CMDSET_ID little-endian, byte 23 is ADDR_W (log2 of the array bytes), and all other bytes are 0. Indices outside that range return 0, and so do reads in program and protect modes.
- R14: In query and status-read modes, any command other than the R4 codes is ignored. So are unlisted codes in array-read and ID modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8*BUS_BYTES | Write data; command in bits 7:0 |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe |
| bus_size | input | 3 | Transfer size in bytes |
| bus_rdata | output | 8*BUS_BYTES | Read data (combinational) |
| mem_addr | output | ADDR_W-log2(BUS_BYTES) | Storage word index |
| mem_rdata | input | 8*BUS_BYTES | Storage read word |
| mem_we | output | BUS_BYTES | Storage per-lane write enables |
| mem_wdata | output | 8*BUS_BYTES | Storage write word |
| erase_req | output | 1 | One-cycle request to the erase sequencer |
| erase_addr | output | ADDR_W | Byte address of the requested erase |

## Verification
The mode register can only be observed through reads. A wrong mode therefore shows on the very next read as the wrong kind of reply: array data where the status byte should be, a zero where an ID word should be, or the reverse. A wrong status update stays hidden until the host enters erase or status-read mode and reads. A wrong program merge shows only after the host returns to array-read mode and reads that word back. The bench therefore follows every random command with frequent reads in whatever mode it expects, so each divergence is caught within a few operations.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

  typedef enum logic [2:0] {
    ST_READ  = 3'd0,
    ST_ID    = 3'd1,
    ST_QUERY = 3'd2,
    ST_PROT  = 3'd3,
    ST_STAT  = 3'd4,
    ST_ERASE = 3'd5,
    ST_WRITE = 3'd6
  } nor_state_e;

  localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_RESET      = 8'hF0;
  localparam logic [7:0] CMD_READ_ID    = 8'h90;
  localparam logic [7:0] CMD_QUERY      = 8'h98;
  localparam logic [7:0] CMD_ERASE_SET  = 8'h20;
  localparam logic [7:0] CMD_CONFIRM    = 8'hD0;
  localparam logic [7:0] CMD_PROG_A     = 8'h40;
  localparam logic [7:0] CMD_PROG_B     = 8'h10;
  localparam logic [7:0] CMD_CLR_STAT   = 8'h50;
  localparam logic [7:0] CMD_LOCK_SET   = 8'h60;
  localparam logic [7:0] CMD_LOCK       = 8'h01;
  localparam logic [7:0] CMD_LOCK_DOWN  = 8'h2F;

  localparam int QUERY_WORD    = 'h55;
  localparam int QUERY_BASE    = 'h10;
  localparam int QUERY_LEN     = 29;

  localparam logic [7:0] STAT_READY = 8'h80;
  localparam logic [7:0] STAT_ERRS  = 8'h30;

endpackage

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int BUS_BYTES = 2,
  localparam int LANE_SH  = $clog2(BUS_BYTES),
  localparam int NA_W     = ADDR_W - LANE_SH
) (
  input  logic              clk,
  input  logic              rst_core_n,
  input  logic              wr_hit,
  input  logic [7:0]        cmd,
  input  logic [NA_W-1:0]   norm_addr,
  input  logic [ADDR_W-1:0] byte_addr,
  output nor_state_e        state_q,
  output logic [7:0]        status_q,
  output logic              prog_fire,
  output logic              erase_req_q,
  output logic [ADDR_W-1:0] erase_addr_q
);

  nor_state_e state_d;
  logic [7:0] status_d;
  logic       erase_fire;
  logic       is_reset_cmd;

  assign is_reset_cmd = (cmd == CMD_READ_ARRAY) || (cmd == CMD_RESET);

  always_comb begin
    state_d    = state_q;
    status_d   = status_q;
    erase_fire = 1'b0;
    prog_fire  = 1'b0;
    if (wr_hit) begin
      if (state_q == ST_WRITE) begin
        prog_fire = 1'b1;
        state_d   = ST_STAT;
      end else if (is_reset_cmd) begin
        state_d = ST_READ;
      end else begin
        unique case (state_q)
          ST_READ, ST_ID: begin
            unique case (cmd)
              CMD_QUERY: begin
                if (norm_addr == NA_W'(QUERY_WORD)) state_d = ST_QUERY;
              end
              CMD_READ_ID:           state_d  = ST_ID;
              CMD_ERASE_SET:         state_d  = ST_ERASE;
              CMD_PROG_A, CMD_PROG_B: state_d = ST_WRITE;
              CMD_CLR_STAT:          status_d = STAT_READY;
              CMD_LOCK_SET:          state_d  = ST_PROT;
              default: ;
            endcase
          end
          ST_ERASE: begin
            if (cmd == CMD_CONFIRM) begin
              erase_fire = 1'b1;
              status_d   = status_q & ~STAT_ERRS;
            end else begin
              status_d   = status_q | STAT_ERRS;
            end
            state_d = ST_STAT;
          end
          ST_PROT: begin
            if (!(cmd == CMD_LOCK || cmd == CMD_CONFIRM || cmd == CMD_LOCK_DOWN))
              status_d = status_q | STAT_ERRS;
            state_d = ST_STAT;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q     <= ST_READ;
      status_q    <= STAT_READY;
      erase_req_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      status_q    <= status_d;
      erase_req_q <= erase_fire;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      erase_addr_q <= '0;
    end else if (erase_fire) begin
      erase_addr_q <= byte_addr;
    end
  end

endmodule

// File: rtl/nor_prog_lanes.sv
module nor_prog_lanes #(
  parameter int BUS_BYTES = 2,
  localparam int BUS_W    = 8 * BUS_BYTES
) (
  input  logic                 prog_fire,
  input  logic [BUS_W-1:0]     new_data,
  input  logic [BUS_W-1:0]     old_data,
  output logic [BUS_BYTES-1:0] lane_we,
  output logic [BUS_W-1:0]     lane_wdata
);

  for (genvar g = 0; g < BUS_BYTES; g++) begin : g_lane
    assign lane_we[g]          = prog_fire;
    assign lane_wdata[8*g +: 8] = old_data[8*g +: 8] & new_data[8*g +: 8];
  end

endmodule

// File: rtl/nor_read_mux.sv
module nor_read_mux
  import nor_cmd_pkg::*;
#(
  parameter int          ADDR_W    = 10,
  parameter int          BUS_BYTES = 2,
  parameter logic [15:0] MFG_CODE  = 16'h0089,
  parameter logic [15:0] CMDSET_ID = 16'h0001,
  localparam int LANE_SH = $clog2(BUS_BYTES),
  localparam int NA_W    = ADDR_W - LANE_SH,
  localparam int BUS_W   = 8 * BUS_BYTES
) (
  input  nor_state_e       state_q,
  input  logic [7:0]       status_q,
  input  logic [NA_W-1:0]  norm_addr,
  input  logic [BUS_W-1:0] mem_rdata,
  input  logic             rd_en,
  output logic [BUS_W-1:0] rdata
);

  logic [31:0] n32;
  logic [31:0] qidx;
  logic [31:0] id_val;
  logic [7:0]  qry_byte;
  logic [31:0] side_val;

  assign n32  = 32'(norm_addr);
  assign qidx = n32 - 32'(QUERY_BASE);

  always_comb begin
    unique case (n32[8:0])
      9'd0:    id_val = 32'(MFG_CODE);
      9'd1:    id_val = 32'h0000_00AD;
      9'd5:    id_val = 32'h0000_8000;
      default: id_val = 32'h0;
    endcase
  end

  always_comb begin
    qry_byte = 8'h00;
    if (n32 >= 32'(QUERY_BASE) && n32 < 32'(QUERY_BASE + QUERY_LEN)) begin
      unique case (qidx)
        32'd0:   qry_byte = 8'h51;
        32'd1:   qry_byte = 8'h52;
        32'd2:   qry_byte = 8'h59;
        32'd3:   qry_byte = CMDSET_ID[7:0];
        32'd4:   qry_byte = CMDSET_ID[15:8];
        32'd23:  qry_byte = 8'(ADDR_W);
        default: qry_byte = 8'h00;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_ID:             side_val = id_val;
      ST_QUERY:          side_val = {24'h0, qry_byte};
      ST_STAT, ST_ERASE: side_val = {24'h0, status_q};
      default:           side_val = 32'h0;
    endcase
  end

  generate
    if (BUS_W >= 32) begin : g_wide
      always_comb begin
        if (!rd_en)                rdata = '0;
        else if (state_q == ST_READ) rdata = mem_rdata;
        else                       rdata = BUS_W'(side_val);
      end
    end else begin : g_narrow
      logic [31:0] unused_hi;
      assign unused_hi = side_val;
      always_comb begin
        if (!rd_en)                rdata = '0;
        else if (state_q == ST_READ) rdata = mem_rdata;
        else                       rdata = unused_hi[BUS_W-1:0];
      end
    end
  endgenerate

endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
  import nor_cmd_pkg::*;
#(
  parameter int          ADDR_W    = 10,
  parameter int          BUS_BYTES = 2,
  parameter logic [15:0] MFG_CODE  = 16'h0089,
  parameter logic [15:0] CMDSET_ID = 16'h0001,
  localparam int LANE_SH = $clog2(BUS_BYTES),
  localparam int NA_W    = ADDR_W - LANE_SH,
  localparam int BUS_W   = 8 * BUS_BYTES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [BUS_W-1:0]     bus_wdata,
  input  logic                 bus_we,
  input  logic                 bus_re,
  input  logic [2:0]           bus_size,
  output logic [BUS_W-1:0]     bus_rdata,
  output logic [NA_W-1:0]      mem_addr,
  input  logic [BUS_W-1:0]     mem_rdata,
  output logic [BUS_BYTES-1:0] mem_we,
  output logic [BUS_W-1:0]     mem_wdata,
  output logic                 erase_req,
  output logic [ADDR_W-1:0]    erase_addr
);

  logic [1:0]  rst_sync_q;
  logic        rst_core_n;
  logic        wr_hit;
  logic        prog_fire;
  nor_state_e  cur_state;
  logic [7:0]  status_q;
  logic [NA_W-1:0] norm_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  assign norm_addr = bus_addr[ADDR_W-1:LANE_SH];
  assign mem_addr  = norm_addr;
  assign wr_hit    = bus_we && (bus_size == 3'(BUS_BYTES));

  nor_cmd_fsm #(
    .ADDR_W    (ADDR_W),
    .BUS_BYTES (BUS_BYTES)
  ) fsm_i (
    .clk          (clk),
    .rst_core_n   (rst_core_n),
    .wr_hit       (wr_hit),
    .cmd          (bus_wdata[7:0]),
    .norm_addr    (norm_addr),
    .byte_addr    (bus_addr),
    .state_q      (cur_state),
    .status_q     (status_q),
    .prog_fire    (prog_fire),
    .erase_req_q  (erase_req),
    .erase_addr_q (erase_addr)
  );

  nor_prog_lanes #(
    .BUS_BYTES (BUS_BYTES)
  ) prog_i (
    .prog_fire  (prog_fire),
    .new_data   (bus_wdata),
    .old_data   (mem_rdata),
    .lane_we    (mem_we),
    .lane_wdata (mem_wdata)
  );

  nor_read_mux #(
    .ADDR_W    (ADDR_W),
    .BUS_BYTES (BUS_BYTES),
    .MFG_CODE  (MFG_CODE),
    .CMDSET_ID (CMDSET_ID)
  ) rmux_i (
    .state_q   (cur_state),
    .status_q  (status_q),
    .norm_addr (norm_addr),
    .mem_rdata (mem_rdata),
    .rd_en     (bus_re),
    .rdata     (bus_rdata)
  );

endmodule

// File: rtl/nor_cmd_decoder_chk.sv
module nor_cmd_decoder_chk
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int BUS_BYTES = 2,
  localparam int NA_W  = ADDR_W - $clog2(BUS_BYTES),
  localparam int BUS_W = 8 * BUS_BYTES
) (
  input logic                 clk,
  input logic                 rst_core_n,
  input logic                 bus_we,
  input logic [2:0]           bus_size,
  input logic [BUS_W-1:0]     bus_wdata,
  input logic [NA_W-1:0]      mem_addr,
  input logic [BUS_W-1:0]     mem_rdata,
  input logic [BUS_BYTES-1:0] mem_we,
  input logic [BUS_W-1:0]     mem_wdata,
  input logic                 erase_req,
  input nor_state_e           cur_state,
  input logic [7:0]           status_q
);

  logic size_ok;
  assign size_ok = (bus_size == 3'(BUS_BYTES));

  // R2
  p_size_ignored_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_we && !size_ok) |=> ($stable(cur_state) && $stable(status_q) && !erase_req));

  // R3
  p_prog_to_status_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_we && size_ok && cur_state == ST_WRITE) |=> (cur_state == ST_STAT));

  // R3: a program never raises a stored bit
  p_no_bit_set_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (mem_we != '0) |-> ((mem_wdata & ~mem_rdata) == '0));

  // R4
  p_reset_cmd_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_we && size_ok && cur_state != ST_WRITE &&
     (bus_wdata[7:0] == 8'hFF || bus_wdata[7:0] == 8'hF0)) |=> (cur_state == ST_READ));

  // R5
  p_query_entry_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cur_state == ST_QUERY && $past(cur_state) != ST_QUERY) |-> ($past(mem_addr) == NA_W'(QUERY_WORD)));

  // R7
  p_erase_pulse_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    erase_req |=> !erase_req);

  // R7
  p_erase_source_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    erase_req |-> ($past(cur_state) == ST_ERASE && $past(bus_wdata[7:0]) == 8'hD0));

endmodule

bind nor_cmd_decoder nor_cmd_decoder_chk #(
  .ADDR_W    (ADDR_W),
  .BUS_BYTES (BUS_BYTES)
) chk_i (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .bus_we     (bus_we),
  .bus_size   (bus_size),
  .bus_wdata  (bus_wdata),
  .mem_addr   (mem_addr),
  .mem_rdata  (mem_rdata),
  .mem_we     (mem_we),
  .mem_wdata  (mem_wdata),
  .erase_req  (erase_req),
  .cur_state  (cur_state),
  .status_q   (status_q)
);

// File: tb/nor_cmd_decoder_tb.sv
`timescale 1ns/1ps
module nor_cmd_decoder_tb_top;

  localparam int AW    = 10;
  localparam int NB    = 2;
  localparam int NA_W  = AW - 1;
  localparam int WORDS = 1 << NA_W;

  localparam int M_READ = 0, M_ID = 1, M_QRY = 2, M_PROT = 3,
                 M_STAT = 4, M_ERASE = 5, M_WRITE = 6;

  logic            clk;
  logic            rst_n;
  logic [AW-1:0]   bus_addr;
  logic [15:0]     bus_wdata;
  logic            bus_we;
  logic            bus_re;
  logic [2:0]      bus_size;
  logic [15:0]     bus_rdata;
  logic [NA_W-1:0] mem_addr;
  logic [15:0]     mem_rdata;
  logic [1:0]      mem_we;
  logic [15:0]     mem_wdata;
  logic            erase_req;
  logic [AW-1:0]   erase_addr;

  logic [15:0] tbmem  [WORDS];
  logic [15:0] exp_mem[WORDS];
  int          m_state;
  logic [7:0]  m_status;
  logic        m_erase;
  logic [AW-1:0] m_eaddr;
  int          checks;
  int          failures;
  bit          done;

  nor_cmd_decoder #(.ADDR_W(AW), .BUS_BYTES(NB)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_size(bus_size), .bus_rdata(bus_rdata),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .erase_req(erase_req), .erase_addr(erase_addr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  assign mem_rdata = tbmem[mem_addr];
  always @(posedge clk) begin
    if (mem_we[0]) tbmem[mem_addr][7:0]  <= mem_wdata[7:0];
    if (mem_we[1]) tbmem[mem_addr][15:8] <= mem_wdata[15:8];
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rdata(logic [AW-1:0] a);
    int n;
    n = int'(a >> 1);
    case (m_state)
      M_READ: return exp_mem[n];
      M_ID: begin
        case (n & 'h1FF)
          0: return 16'h0089;
          1: return 16'h00AD;
          5: return 16'h8000;
          default: return 16'h0000;
        endcase
      end
      M_QRY: begin
        if (n < 'h10 || n > 'h2C) return 16'h0;
        case (n - 'h10)
          0: return 16'h0051;
          1: return 16'h0052;
          2: return 16'h0059;
          3: return 16'h0001;
          23: return 16'(AW);
          default: return 16'h0;
        endcase
      end
      M_STAT, M_ERASE: return {8'h00, m_status};
      default: return 16'h0;
    endcase
  endfunction

  function automatic string state_tag();
    case (m_state)
      M_READ: return "R1";
      M_ID: return "R6";
      M_QRY: return "R13";
      M_STAT, M_ERASE: return "R11";
      default: return "R14";
    endcase
  endfunction

  task automatic model_write(logic [AW-1:0] a, logic [15:0] d, logic [2:0] sz);
    logic [7:0] c;
    int n;
    m_erase = 1'b0;
    if (sz != 3'd2) return;
    n = int'(a >> 1);
    c = d[7:0];
    if (m_state == M_WRITE) begin
      exp_mem[n] = exp_mem[n] & d;
      m_state = M_STAT;
      return;
    end
    if (c == 8'hFF || c == 8'hF0) begin
      m_state = M_READ;
      return;
    end
    case (m_state)
      M_READ, M_ID: begin
        case (c)
          8'h98: if (n == 'h55) m_state = M_QRY;
          8'h90: m_state = M_ID;
          8'h20: m_state = M_ERASE;
          8'h40, 8'h10: m_state = M_WRITE;
          8'h50: m_status = 8'h80;
          8'h60: m_state = M_PROT;
          default: ;
        endcase
      end
      M_ERASE: begin
        if (c == 8'hD0) begin
          m_erase = 1'b1;
          m_eaddr = a;
          m_status = m_status & 8'hCF;
        end else m_status = m_status | 8'h30;
        m_state = M_STAT;
      end
      M_PROT: begin
        if (!(c == 8'h01 || c == 8'hD0 || c == 8'h2F)) m_status = m_status | 8'h30;
        m_state = M_STAT;
      end
      default: ;
    endcase
  endtask

  task automatic wr(logic [AW-1:0] a, logic [15:0] d, logic [2:0] sz = 3'd2);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_size = sz; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    model_write(a, d, sz);
    chk("R7 erase_req", 32'(erase_req), 32'(m_erase));
    if (m_erase) chk("R7 erase_addr", 32'(erase_addr), 32'(m_eaddr));
  endtask

  task automatic rd(logic [AW-1:0] a, string tag = "");
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    #1;
    chk(tag == "" ? state_tag() : tag, 32'(bus_rdata), 32'(exp_rdata(a)));
    bus_re = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] cmds[14];
    void'($urandom(32'd20240611));
    checks = 0; failures = 0; done = 1'b0;
    for (int i = 0; i < WORDS; i++) begin
      tbmem[i]   = 16'($urandom);
      exp_mem[i] = tbmem[i];
    end
    m_state = M_READ; m_status = 8'h80; m_erase = 1'b0; m_eaddr = '0;
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0;
    bus_re = 1'b0; bus_size = 3'd2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 erase_req", 32'(erase_req), 32'h0);
    rd(10'h000, "R1");
    rd(10'h3FE, "R1");
    // R11: read strobe low gives zero
    bus_addr = 10'h004; #1;
    chk("R11 rd_en low", 32'(bus_rdata), 32'h0);
    // R2 size mismatch ignored
    wr(10'h010, 16'h0040, 3'd1);
    wr(10'h010, 16'h0040, 3'd4);
    rd(10'h010, "R2");
    // R5 query at wrong address dropped, then at 0x55 (byte 0xAA)
    wr(10'h000, 16'h0098);
    rd(10'h020, "R5");
    wr(10'h0AA, 16'h0098);
    rd(10'h020, "R13");
    rd(10'h026, "R13");
    rd(10'h02E, "R13");
    rd(10'h05A, "R13");
    // R14 command ignored in query mode
    wr(10'h000, 16'h0040);
    rd(10'h022, "R14");
    wr(10'h000, 16'h00FF);
    rd(10'h022, "R4");
    // R6 / R12 ID replies
    wr(10'h000, 16'h0090);
    rd(10'h000, "R6");
    rd(10'h002, "R12");
    rd(10'h004, "R6");
    rd(10'h00A, "R6");
    rd(10'h006, "R6");
    rd(10'h400 - 10'h3FE + 10'h008, "R6");
    wr(10'h000, 16'h00F0);
    // R8 / R3 program
    wr(10'h040, 16'h0040);
    wr(10'h040, 16'h0F3C);
    rd(10'h040, "R11");
    wr(10'h000, 16'h00FF);
    rd(10'h040, "R3");
    wr(10'h044, 16'h0010);
    wr(10'h044, 16'h00FF);
    wr(10'h000, 16'h00FF);
    rd(10'h044, "R3");
    // R7 erase confirm and reject
    wr(10'h000, 16'h0020);
    rd(10'h000, "R11");
    wr(10'h124, 16'h00D0);
    wr(10'h000, 16'h00FF);
    wr(10'h000, 16'h0020);
    wr(10'h000, 16'h0033);
    rd(10'h000, "R7");
    // R14: clear status ignored in status mode
    wr(10'h000, 16'h0050);
    rd(10'h000, "R14");
    // R10 clear status
    wr(10'h000, 16'h00FF);
    wr(10'h000, 16'h0050);
    wr(10'h000, 16'h0020);
    rd(10'h000, "R10");
    wr(10'h000, 16'h00FF);
    // R9 protect
    wr(10'h000, 16'h0060);
    rd(10'h000, "R9");
    wr(10'h000, 16'h002F);
    rd(10'h000, "R9");
    wr(10'h000, 16'h00F0);
    wr(10'h000, 16'h0060);
    wr(10'h000, 16'h0077);
    rd(10'h000, "R9");
    wr(10'h000, 16'h00FF);

    // constrained random
    cmds = '{16'h00FF, 16'h00F0, 16'h0090, 16'h0098, 16'h0020, 16'h00D0,
             16'h0040, 16'h0010, 16'h0050, 16'h0060, 16'h0001, 16'h002F,
             16'h0033, 16'h0000};
    for (int it = 0; it < 1500; it++) begin
      int r;
      logic [AW-1:0] a;
      logic [15:0] d;
      logic [2:0] sz;
      r = int'($urandom % 10);
      case ($urandom % 4)
        0: a = 10'h0AA;
        1: a = AW'(($urandom % 16) * 2);
        2: a = AW'('h20 + ($urandom % 32) * 2);
        default: a = AW'($urandom);
      endcase
      if (r < 4) rd(a);
      else begin
        if (m_state == M_WRITE && ($urandom % 2) == 0) d = 16'($urandom);
        else d = {8'($urandom), cmds[$urandom % 14][7:0]};
        sz = (($urandom % 12) == 0) ? 3'd1 : 3'd2;
        wr(a, d, sz);
      end
    end
    wr(10'h000, 16'h00FF);
    wr(10'h000, 16'h00FF);
    for (int i = 0; i < 32; i++) rd(AW'(i * 2), "R3");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule